// File: doc/BRIEF.md
# Threshold Byte FIFO Pair with Self-Clearing Flush

This block sits between a host register interface and a serial bus engine. It holds two byte queues of equal depth. The host fills the transmit queue and the engine drains it. The engine fills the receive queue and the host drains it. Each queue has a programmable level threshold. A threshold flag fires when the transmit queue runs low, or when the receive queue has gathered enough bytes. Seven status sources are latched into a raw status vector. A mask selects which of them drive the single interrupt line. A write-one-to-clear input clears the latched bits.

Each direction has its own flush. A one-cycle request sets a busy bit. While the bit is set, the queue drops one entry per clock. The bit clears itself once the queue is empty. While a flush runs, every access to that queue is ignored and its data output reads zero. Software polls the busy bit and does not touch the queue until it clears.

Top module: `serial_fifo_pair`

## Requirements
- R1: While reset is held, the flush busy bits, the raw status, the masked status, the interrupt and both data outputs are all zero.
- R2: Each queue holds 16 bytes and returns them in the order they were written. The data output shows the oldest byte, and shows zero when the queue is empty.
- R3: A host write while the transmit queue holds 16 bytes, and no flush is running, is dropped. It sets raw status bit 3 at the next edge, and that bit stays set until it is cleared.
- R4: Raw bit 1 is set when the transmit entry count is at or below the transmit threshold. Raw bit 5 is set when the receive entry count is at or above the receive threshold. Both thresholds range from 0 to 15.
- R5: Raw bit 0 means the transmit queue is empty, bit 2 that it is full, bit 4 that the receive queue is empty and bit 6 that it is full.
- R6: A flush request on an idle queue sets its busy bit at the next edge. Each following edge removes one entry. The bit clears at the first edge at which the queue is already empty, so a queue of n entries stays busy for n+1 cycles. A request made while the queue is busy has no effect.
- R7: While a queue's flush is busy, pushes and pops on that queue are dropped, its data output reads zero, and a write to a full transmit queue does not set raw bit 3.
- R8: Every raw bit is set at each edge at which its condition held in the cycle before. A 1 on the matching clear bit clears it unless the condition holds in that same cycle.
- R9: The masked status equals the raw status ANDed with the mask, and the interrupt output is high exactly when any masked bit is set.
- R10: An engine push into a full receive queue is dropped. A pop from an empty queue is ignored and the count does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_thresh | input | 4 | Transmit nearly-empty threshold |
| rx_thresh | input | 4 | Receive nearly-full threshold |
| flush_tx_req | input | 1 | Pulse that starts a transmit flush |
| flush_rx_req | input | 1 | Pulse that starts a receive flush |
| flush_tx_busy | output | 1 | Transmit flush in progress; clears itself |
| flush_rx_busy | output | 1 | Receive flush in progress; clears itself |
| host_tx_wr | input | 1 | Host write strobe into the transmit queue |
| host_tx_wdata | input | 8 | Host write byte |
| host_rx_rd | input | 1 | Host read strobe; pops the receive queue |
| host_rx_rdata | output | 8 | Oldest receive byte, zero if empty or flushing |
| eng_tx_pop | input | 1 | Engine pop of the transmit queue |
| eng_tx_data | output | 8 | Oldest transmit byte, zero if empty or flushing |
| eng_rx_push | input | 1 | Engine push into the receive queue |
| eng_rx_wdata | input | 8 | Engine push byte |
| irq_mask | input | 7 | Per-source interrupt enable |
| irq_clear | input | 7 | Write-one-to-clear for the raw status |
| raw_status | output | 7 | Latched status sources |
| masked_status | output | 7 | Raw status ANDed with mask |
| irq | output | 1 | OR of all masked status bits |

## Verification
The assertions assume that reset is applied from time zero and that the threshold inputs are ordinary levels. They also assume the flush request is a plain pulse that may come at any time, even while the queue is busy or empty. The bench respects these assumptions. It keeps reset low for the first cycles and changes thresholds and masks only between stimulus phases. It drives every strobe from random draws at the falling edge, so each input is steady across the rising edge that samples it. Phase weights push the queues against both ends: writes into a full queue, pops from an empty queue, and flushes issued while the queues are partly filled and while they are already busy.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
  localparam int N_SRC        = 7;
  localparam int SRC_TX_EMPTY = 0;
  localparam int SRC_TX_LOW   = 1;
  localparam int SRC_TX_FULL  = 2;
  localparam int SRC_TX_OVR   = 3;
  localparam int SRC_RX_EMPTY = 4;
  localparam int SRC_RX_HIGH  = 5;
  localparam int SRC_RX_FULL  = 6;
  typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  input  logic          flush_req,
  output logic          flush_busy,
  output logic [CW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          busy;

  wire is_full    = (cnt == CW'(DEPTH));
  wire is_empty   = (cnt == '0);
  wire do_push    = push & ~busy & ~is_full;
  wire do_pop     = pop  & ~busy & ~is_empty;
  wire flush_step = busy & ~is_empty;
  wire advance_rd = do_pop | flush_step;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (advance_rd) rp <= rp + AW'(1);
      case ({do_push, advance_rd})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      if (busy) begin
        if (is_empty) busy <= 1'b0;
      end else if (flush_req) begin
        busy <= 1'b1;
      end
    end
  end

  assign head       = (busy || is_empty) ? '0 : mem[rp];
  assign flush_busy = busy;
  assign level      = cnt;
endmodule

// File: rtl/irq_status.sv
module irq_status
  import fifo_pair_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t evt,
  input  src_vec_t mask,
  input  src_vec_t clear,
  output src_vec_t raw,
  output src_vec_t masked,
  output logic     irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= (raw & ~clear) | evt;
  end

  assign masked = raw & mask;
  assign irq    = |masked;
endmodule

// File: rtl/serial_fifo_pair.sv
module serial_fifo_pair
  import fifo_pair_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    tx_thresh,
  input  logic [AW-1:0]    rx_thresh,
  input  logic             flush_tx_req,
  input  logic             flush_rx_req,
  output logic             flush_tx_busy,
  output logic             flush_rx_busy,
  input  logic             host_tx_wr,
  input  logic [DW-1:0]    host_tx_wdata,
  input  logic             host_rx_rd,
  output logic [DW-1:0]    host_rx_rdata,
  input  logic             eng_tx_pop,
  output logic [DW-1:0]    eng_tx_data,
  input  logic             eng_rx_push,
  input  logic [DW-1:0]    eng_rx_wdata,
  input  logic [N_SRC-1:0] irq_mask,
  input  logic [N_SRC-1:0] irq_clear,
  output logic [N_SRC-1:0] raw_status,
  output logic [N_SRC-1:0] masked_status,
  output logic             irq
);
  function automatic logic at_or_below(input logic [CW-1:0] lvl, input logic [AW-1:0] thr);
    return lvl <= {1'b0, thr};
  endfunction

  function automatic logic at_or_above(input logic [CW-1:0] lvl, input logic [AW-1:0] thr);
    return lvl >= {1'b0, thr};
  endfunction

  function automatic logic is_full_lvl(input logic [CW-1:0] lvl);
    return lvl == CW'(DEPTH);
  endfunction

  logic [CW-1:0] tx_level, rx_level;
  logic          tx_ovr_evt;
  src_vec_t      evt;

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(host_tx_wr), .push_data(host_tx_wdata),
    .pop(eng_tx_pop), .head(eng_tx_data),
    .flush_req(flush_tx_req), .flush_busy(flush_tx_busy),
    .level(tx_level)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(eng_rx_push), .push_data(eng_rx_wdata),
    .pop(host_rx_rd), .head(host_rx_rdata),
    .flush_req(flush_rx_req), .flush_busy(flush_rx_busy),
    .level(rx_level)
  );

  assign tx_ovr_evt = host_tx_wr & ~flush_tx_busy & is_full_lvl(tx_level);

  always_comb begin
    evt               = '0;
    evt[SRC_TX_EMPTY] = (tx_level == '0);
    evt[SRC_TX_LOW]   = at_or_below(tx_level, tx_thresh);
    evt[SRC_TX_FULL]  = is_full_lvl(tx_level);
    evt[SRC_TX_OVR]   = tx_ovr_evt;
    evt[SRC_RX_EMPTY] = (rx_level == '0);
    evt[SRC_RX_HIGH]  = at_or_above(rx_level, rx_thresh);
    evt[SRC_RX_FULL]  = is_full_lvl(rx_level);
  end

  irq_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .evt(evt), .mask(irq_mask), .clear(irq_clear),
    .raw(raw_status), .masked(masked_status), .irq(irq)
  );
endmodule

// File: rtl/fifo_pair_chk.sv
module fifo_pair_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_tx_wr,
  input logic          flush_tx_busy,
  input logic          flush_rx_busy,
  input logic [DW-1:0] host_rx_rdata,
  input logic [DW-1:0] eng_tx_data,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic [AW-1:0] rx_thresh,
  input logic [6:0]    raw_status,
  input logic [6:0]    irq_clear
);
  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH)));

  assert_ovr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_tx_wr && !flush_tx_busy && tx_level == CW'(DEPTH)) |=> raw_status[3]);

  assert_ovr_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status[3] && !irq_clear[3]) |=> raw_status[3]);

  assert_rx_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= {1'b0, rx_thresh}) |=> raw_status[5]);

  assert_tx_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |=> raw_status[0]);

  assert_flush_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_tx_busy && tx_level == '0) |=> !flush_tx_busy);

  assert_flush_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_tx_busy && tx_level != '0) |=> (tx_level == $past(tx_level) - CW'(1)));

  assert_flush_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_rx_busy |-> host_rx_rdata == '0) and (flush_tx_busy |-> eng_tx_data == '0));
endmodule

bind serial_fifo_pair fifo_pair_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_tx_wr(host_tx_wr),
  .flush_tx_busy(flush_tx_busy), .flush_rx_busy(flush_rx_busy),
  .host_rx_rdata(host_rx_rdata), .eng_tx_data(eng_tx_data),
  .tx_level(tx_level), .rx_level(rx_level), .rx_thresh(rx_thresh),
  .raw_status(raw_status), .irq_clear(irq_clear)
);

// File: tb/sim_serial_fifo_pair.sv
module sim_serial_fifo_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tx_thresh = '0, rx_thresh = '0;
  logic       flush_tx_req = 0, flush_rx_req = 0;
  logic       flush_tx_busy, flush_rx_busy;
  logic       host_tx_wr = 0, host_rx_rd = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [7:0] host_tx_wdata = '0, eng_rx_wdata = '0;
  logic [7:0] host_rx_rdata, eng_tx_data;
  logic [6:0] irq_mask = '0, irq_clear = '0;
  logic [6:0] raw_status, masked_status;
  logic       irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_fifo_pair u0 (.*);

  // Behavioural reference model
  byte unsigned tq[$], rq[$];
  bit         tb, rb;
  bit [6:0]   mraw, prev_clr;

  always @(posedge clk) begin
    if (!rst_n) begin
      tq.delete(); rq.delete(); tb = 0; rb = 0; mraw = '0; prev_clr = '0;
    end else begin
      bit [6:0] ev;
      bit pu, po;
      ev[0] = tq.size() == 0;
      ev[1] = tq.size() <= int'(tx_thresh);
      ev[2] = tq.size() == 16;
      ev[3] = host_tx_wr && !tb && tq.size() == 16;
      ev[4] = rq.size() == 0;
      ev[5] = rq.size() >= int'(rx_thresh);
      ev[6] = rq.size() == 16;
      mraw = (mraw & ~irq_clear) | ev;
      prev_clr = irq_clear;
      if (tb) begin
        if (tq.size() == 0) tb = 0; else void'(tq.pop_front());
      end else begin
        pu = host_tx_wr && tq.size() < 16;
        po = eng_tx_pop && tq.size() > 0;
        if (po) void'(tq.pop_front());
        if (pu) tq.push_back(host_tx_wdata);
        if (flush_tx_req) tb = 1;
      end
      if (rb) begin
        if (rq.size() == 0) rb = 0; else void'(rq.pop_front());
      end else begin
        pu = eng_rx_push && rq.size() < 16;
        po = host_rx_rd && rq.size() > 0;
        if (po) void'(rq.pop_front());
        if (pu) rq.push_back(eng_rx_wdata);
        if (flush_rx_req) rb = 1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string raw_tag(input int i, input bit cleared);
    if (cleared) return "R8 raw bit";
    case (i)
      3:       return "R3 overrun bit";
      1, 5:    return "R4 threshold bit";
      default: return "R5 empty/full bit";
    endcase
  endfunction

  task automatic compare();
    int et, er;
    et = (tb || tq.size() == 0) ? 0 : int'(tq[0]);
    er = (rb || rq.size() == 0) ? 0 : int'(rq[0]);
    check(tb ? "R7 tx data while flushing" : "R2,R10 tx head", int'(eng_tx_data), et);
    check(rb ? "R7 rx data while flushing" : "R2,R10 rx head", int'(host_rx_rdata), er);
    check("R6 tx flush busy", int'(flush_tx_busy), int'(tb));
    check("R6 rx flush busy", int'(flush_rx_busy), int'(rb));
    for (int i = 0; i < 7; i++)
      check(raw_tag(i, prev_clr[i]), int'(raw_status[i]), int'(mraw[i]));
    check("R9 masked status", int'(masked_status), int'(mraw & irq_mask));
    check("R9 irq", int'(irq), int'(|(mraw & irq_mask)));
  endtask

  function automatic bit roll(input int pct);
    return $urandom_range(99) < pct;
  endfunction

  task automatic phase(input int n, input int p_wr, input int p_pop, input int p_push,
                       input int p_rd, input int p_fl, input int p_clr);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare();
      host_tx_wr    = roll(p_wr);
      host_tx_wdata = 8'($urandom);
      eng_tx_pop    = roll(p_pop);
      eng_rx_push   = roll(p_push);
      eng_rx_wdata  = 8'($urandom);
      host_rx_rd    = roll(p_rd);
      flush_tx_req  = roll(p_fl);
      flush_rx_req  = roll(p_fl);
      irq_clear     = roll(p_clr) ? 7'($urandom) : 7'd0;
    end
  endtask

  task automatic quiet();
    @(negedge clk);
    host_tx_wr = 0; eng_tx_pop = 0; eng_rx_push = 0; host_rx_rd = 0;
    flush_tx_req = 0; flush_rx_req = 0; irq_clear = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    irq_mask = 7'h7f;
    repeat (3) begin
      @(negedge clk);
      check("R1 reset raw", int'(raw_status), 0);
      check("R1 reset masked/irq", int'({masked_status, irq}), 0);
      check("R1 reset busy", int'({flush_tx_busy, flush_rx_busy}), 0);
      check("R1 reset data", int'({eng_tx_data, host_rx_rdata}), 0);
    end
    rst_n = 1'b1;
    tx_thresh = 4'd3; rx_thresh = 4'd8;
    phase(60, 90, 0, 90, 0, 0, 0);      // fill both queues, overrun R3, full drop R10
    quiet();
    phase(30, 0, 0, 0, 0, 0, 0);        // overrun stays latched R3
    phase(80, 0, 60, 0, 60, 0, 40);     // drain, clears R8, pops on empty R10
    irq_mask = 7'h2a; tx_thresh = 4'd0; rx_thresh = 4'd15;
    phase(500, 50, 50, 50, 50, 2, 10);
    irq_mask = 7'h55; tx_thresh = 4'd15; rx_thresh = 4'd0;
    phase(400, 70, 20, 70, 20, 8, 20);  // flush while partly filled R6, R7
    irq_mask = 7'($urandom); tx_thresh = 4'($urandom); rx_thresh = 4'($urandom);
    phase(60, 100, 0, 100, 0, 0, 0);
    phase(40, 100, 0, 100, 0, 30, 0);   // flush of full queues and writes while busy R7
    irq_mask = 7'h7f; tx_thresh = 4'd7; rx_thresh = 4'd7;
    phase(1500, 45, 45, 45, 45, 3, 15);
    quiet();
    phase(20, 0, 0, 0, 0, 0, 100);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule